// File: doc/BRIEF.md
# Speculative dual-issue instruction queue

This block is a six-entry in-order buffer placed between an instruction fetcher and a dispatch stage. Each cycle it can take in up to two fetched instructions and hand up to two of the oldest ones to the execution units. It tells the fetcher how many entries are free, so the fetcher never offers more than the queue can hold.

The queue tracks one outstanding predicted conditional branch. Once the predictor marks a prediction, every instruction written from that cycle on carries a speculative tag, which is visible on the dispatch slots. Non-branch speculative instructions may still be dispatched. A branch that sits in the speculative shadow is held at the head until the earlier branch resolves, and it also blocks everything behind it. A correct resolution clears all tags. A misprediction removes every speculative entry still in the queue and keeps the older, non-speculative ones.

Fetch side handshake: `fetch_vld[0]` offers the older instruction and `fetch_vld[1]` offers the younger one. Slot k is taken on a clock edge when `fetch_vld[k]` and `fetch_rdy[k]` are both high. Slot 1 is taken only when slot 0 is taken in the same cycle. The ready signals come from the free count and are dropped during a flush. Dispatch side handshake: `disp_vld` does not depend on `disp_rdy`. When `disp_rdy` is high, every slot shown valid leaves the queue. When `disp_rdy` is low, nothing leaves.

Top module: `spec_iq`

## Requirements
- R1: After reset the queue is empty: `free_slots` = 6, `fetch_rdy` = 2'b11 and `disp_vld` = 2'b00.
- R2: `fetch_rdy[0]` is high exactly when at least one entry is free and `fetch_rdy[1]` exactly when at least two are free, with no flush in progress. Occupancy never exceeds six, and offers made while not ready are dropped.
- R3: Instructions leave in the order they were written. Slot 0 (`disp_ins0`/`disp_addr0`) always holds the oldest entry in the queue, and slot 1 holds the next oldest.
- R4: `disp_vld[1]` is high only when `disp_vld[0]` is high and a second unblocked entry is present.
- R5: While `disp_stall` is high, `disp_vld` = 2'b00 and no entry leaves the queue.
- R6: While `disp_rdy` is low, no entry leaves the queue.
- R7: When `bp_predict` is accepted (no branch outstanding, or a resolution in the same cycle), the entries written in that cycle and in every later cycle are speculative. Their `disp_spec` bit reads 1 until the branch resolves. A `bp_predict` pulse while a branch is outstanding is ignored.
- R8: A resolution with `bp_mispredict` = 0 clears the speculative tag of every queued entry. From the next cycle on, those entries dispatch with `disp_spec` = 0.
- R9: A resolution with `bp_mispredict` = 1 removes all speculative entries and keeps the older, non-speculative ones. In that cycle `fetch_rdy` = 2'b00 (writes are ignored) and `disp_vld` = 2'b00.
- R10: A speculative entry marked as a branch is not dispatched while its branch is outstanding. While it is at the head, `disp_vld` = 2'b00. While it is second, only slot 0 may be valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld | input | 2 | Fetch offer valid; bit 0 is the older instruction |
| fetch_rdy | output | 2 | Fetch slot may be accepted |
| fetch_ins0 | input | 32 | Instruction word, fetch slot 0 |
| fetch_addr0 | input | 32 | Instruction address, fetch slot 0 |
| fetch_br0 | input | 1 | Slot 0 instruction is a branch |
| fetch_ins1 | input | 32 | Instruction word, fetch slot 1 |
| fetch_addr1 | input | 32 | Instruction address, fetch slot 1 |
| fetch_br1 | input | 1 | Slot 1 instruction is a branch |
| free_slots | output | 3 | Number of free queue entries |
| bp_predict | input | 1 | A branch was predicted; speculation starts this cycle |
| bp_resolve | input | 1 | The outstanding branch resolves this cycle |
| bp_mispredict | input | 1 | With `bp_resolve`: the prediction was wrong |
| disp_stall | input | 1 | Suppress all dispatch this cycle |
| disp_rdy | input | 1 | Dispatch stage accepts the valid slots |
| disp_vld | output | 2 | Dispatch slot valid; bit 0 is the older slot |
| disp_ins0 | output | 32 | Instruction word, dispatch slot 0 |
| disp_addr0 | output | 32 | Instruction address, dispatch slot 0 |
| disp_spec0 | output | 1 | Dispatch slot 0 is speculative |
| disp_ins1 | output | 32 | Instruction word, dispatch slot 1 |
| disp_addr1 | output | 32 | Instruction address, dispatch slot 1 |
| disp_spec1 | output | 1 | Dispatch slot 1 is speculative |

## Verification
The bench fills the queue to six entries and then offers more. A design that miscounts free entries would either overwrite the oldest entries or accept too few. It places a speculative branch both at the head and in the second slot. A design that ignores the shadow would dispatch that branch early, and a design that checks only slot 1 would let it out through slot 0. It raises a misprediction while fetch offers are pending and while older non-speculative entries are queued. Here a faulty flush would keep a wrong-path write, drop the surviving older entries, or leave the occupancy count wrong. Random traffic that mixes stalls, partial readiness, ignored predicts and resolutions, all checked against a bench model, catches ordering slips in the circular pointers and speculative tags that correct resolutions fail to clear.

// File: rtl/spec_iq_pkg.sv
package spec_iq_pkg;
  localparam int INS_W  = 32;
  localparam int ADDR_W = 32;

  typedef struct packed {
    logic              vld;
    logic              spec;
    logic              isbr;
    logic [ADDR_W-1:0] addr;
    logic [INS_W-1:0]  ins;
  } iq_ent_t;
endpackage

// File: rtl/spec_iq_ctl.sv
module spec_iq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic bp_predict,
  input  logic bp_resolve,
  input  logic bp_mispredict,
  output logic spec_active,
  output logic wr_spec,
  output logic kill_spec,
  output logic clr_spec
);
  logic pred_acc;

  // one branch in flight; a new prediction is taken only when the slot frees this cycle
  assign pred_acc  = bp_predict && (!spec_active || bp_resolve);
  assign kill_spec = bp_resolve && spec_active && bp_mispredict;
  assign clr_spec  = bp_resolve && spec_active && !bp_mispredict;
  assign wr_spec   = (spec_active && !bp_resolve) || pred_acc;

  always_ff @(posedge clk) begin
    if (!rst_n)          spec_active <= 1'b0;
    else if (pred_acc)   spec_active <= 1'b1;
    else if (bp_resolve) spec_active <= 1'b0;
  end

  // R7: a predict pulse while one branch is pending does not end speculation
  a_r7_single_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_active && !bp_resolve) |=> spec_active);
endmodule

// File: rtl/spec_iq_store.sv
module spec_iq_store
  import spec_iq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    wr_n,
  input  iq_ent_t       wr_e0,
  input  iq_ent_t       wr_e1,
  input  logic [1:0]    pop_n,
  input  logic          clr_spec,
  input  logic          kill_spec,
  output logic [CW-1:0] count,
  output iq_ent_t       head_e0,
  output iq_ent_t       head_e1,
  output logic [CW-1:0] spec_cnt
);
  iq_ent_t       ents [DEPTH];
  logic [PW-1:0] head, idx1, tail0, tail1;

  function automatic logic [PW-1:0] wrap(input logic [PW:0] v);
    return (v >= (PW+1)'(DEPTH)) ? PW'(v - (PW+1)'(DEPTH)) : PW'(v);
  endfunction

  assign idx1  = wrap({1'b0, head} + (PW+1)'(1));
  assign tail0 = wrap({1'b0, head} + (PW+1)'(count));
  assign tail1 = wrap({1'b0, head} + (PW+1)'(count) + (PW+1)'(1));

  assign head_e0 = ents[head];
  assign head_e1 = ents[idx1];

  always_comb begin
    spec_cnt = '0;
    for (int i = 0; i < DEPTH; i++)
      spec_cnt = spec_cnt + CW'(ents[i].vld & ents[i].spec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
    end else if (kill_spec) begin
      // speculative entries are always the youngest, so the tail just moves back
      for (int i = 0; i < DEPTH; i++)
        if (ents[i].spec) ents[i] <= '0;
      count <= count - spec_cnt;
    end else begin
      if (clr_spec)
        for (int i = 0; i < DEPTH; i++) ents[i].spec <= 1'b0;
      if (pop_n != 2'd0) ents[head].vld <= 1'b0;
      if (pop_n == 2'd2) ents[idx1].vld <= 1'b0;
      if (wr_n != 2'd0)  ents[tail0] <= wr_e0;
      if (wr_n == 2'd2)  ents[tail1] <= wr_e1;
      head  <= wrap({1'b0, head} + (PW+1)'(pop_n));
      count <= count + CW'(wr_n) - CW'(pop_n);
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r2_write_room: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(wr_n) <= CW'(DEPTH) - count);
  a_r9_flush_clean: assert property (@(posedge clk) disable iff (!rst_n)
    kill_spec |=> (spec_cnt == '0));
  a_r3_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_n != 2'd0) |-> head_e0.vld);
endmodule

// File: rtl/spec_iq_pick.sv
module spec_iq_pick
  import spec_iq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  iq_ent_t    head_e0,
  input  iq_ent_t    head_e1,
  input  logic       hold,
  input  logic       disp_rdy,
  output logic [1:0] disp_vld,
  output logic [1:0] pop_n
);
  logic ok0, ok1;

  // a speculative branch may not leave; it also shadows the slot behind it
  assign ok0 = head_e0.vld && !(head_e0.spec && head_e0.isbr);
  assign ok1 = ok0 && head_e1.vld && !(head_e1.spec && head_e1.isbr);

  assign disp_vld = hold ? 2'b00 : {ok1, ok0};
  assign pop_n    = !disp_rdy   ? 2'd0 :
                    disp_vld[1] ? 2'd2 :
                    disp_vld[0] ? 2'd1 : 2'd0;

  a_r4_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    disp_vld[1] |-> disp_vld[0]);
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (pop_n == 2'd0));
  a_r10_shadow_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_n != 2'd0) |-> !(head_e0.spec && head_e0.isbr));
endmodule

// File: rtl/spec_iq.sv
module spec_iq
  import spec_iq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fetch_vld,
  output logic [1:0]        fetch_rdy,
  input  logic [INS_W-1:0]  fetch_ins0,
  input  logic [ADDR_W-1:0] fetch_addr0,
  input  logic              fetch_br0,
  input  logic [INS_W-1:0]  fetch_ins1,
  input  logic [ADDR_W-1:0] fetch_addr1,
  input  logic              fetch_br1,
  output logic [CW-1:0]     free_slots,
  input  logic              bp_predict,
  input  logic              bp_resolve,
  input  logic              bp_mispredict,
  input  logic              disp_stall,
  input  logic              disp_rdy,
  output logic [1:0]        disp_vld,
  output logic [INS_W-1:0]  disp_ins0,
  output logic [ADDR_W-1:0] disp_addr0,
  output logic              disp_spec0,
  output logic [INS_W-1:0]  disp_ins1,
  output logic [ADDR_W-1:0] disp_addr1,
  output logic              disp_spec1
);
  logic          spec_active, wr_spec, kill_spec, clr_spec;
  logic          wr0, wr1;
  logic [1:0]    wr_n, pop_n;
  logic [CW-1:0] count, spec_cnt;
  iq_ent_t       w0, w1, e0, e1;

  spec_iq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .bp_predict(bp_predict), .bp_resolve(bp_resolve), .bp_mispredict(bp_mispredict),
    .spec_active(spec_active), .wr_spec(wr_spec),
    .kill_spec(kill_spec), .clr_spec(clr_spec)
  );

  assign free_slots   = CW'(DEPTH) - count;
  assign fetch_rdy[0] = !kill_spec && (free_slots >= CW'(1));
  assign fetch_rdy[1] = !kill_spec && (free_slots >= CW'(2));

  assign wr0  = fetch_vld[0] && fetch_rdy[0];
  assign wr1  = wr0 && fetch_vld[1] && fetch_rdy[1];
  assign wr_n = wr1 ? 2'd2 : (wr0 ? 2'd1 : 2'd0);

  assign w0 = '{vld: 1'b1, spec: wr_spec, isbr: fetch_br0, addr: fetch_addr0, ins: fetch_ins0};
  assign w1 = '{vld: 1'b1, spec: wr_spec, isbr: fetch_br1, addr: fetch_addr1, ins: fetch_ins1};

  spec_iq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_n(wr_n), .wr_e0(w0), .wr_e1(w1), .pop_n(pop_n),
    .clr_spec(clr_spec), .kill_spec(kill_spec),
    .count(count), .head_e0(e0), .head_e1(e1), .spec_cnt(spec_cnt)
  );

  spec_iq_pick u_pick (
    .clk(clk), .rst_n(rst_n),
    .head_e0(e0), .head_e1(e1),
    .hold(disp_stall || kill_spec), .disp_rdy(disp_rdy),
    .disp_vld(disp_vld), .pop_n(pop_n)
  );

  assign disp_ins0  = e0.ins;
  assign disp_addr0 = e0.addr;
  assign disp_spec0 = e0.spec;
  assign disp_ins1  = e1.ins;
  assign disp_addr1 = e1.addr;
  assign disp_spec1 = e1.spec;

  // R7: tagged entries only exist while a branch is outstanding
  a_r7_no_orphan_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_cnt != '0) |-> spec_active);
  // R8: a correct resolution leaves no tagged entry behind
  a_r8_resolve_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_spec && !bp_predict) |=> (spec_cnt == '0));
  // R9: wrong-path fetches are never accepted during a flush
  a_r9_no_write_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_resolve && bp_mispredict && spec_active) |=> (count == $past(count) - $past(spec_cnt)));
endmodule

// File: tb/spec_iq_tb_top.sv
module spec_iq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fetch_vld = '0;
  logic [1:0]  fetch_rdy;
  logic [31:0] fetch_ins0 = '0, fetch_addr0 = '0, fetch_ins1 = '0, fetch_addr1 = '0;
  logic        fetch_br0 = 1'b0, fetch_br1 = 1'b0;
  logic [2:0]  free_slots;
  logic        bp_predict = 1'b0, bp_resolve = 1'b0, bp_mispredict = 1'b0;
  logic        disp_stall = 1'b0, disp_rdy = 1'b0;
  logic [1:0]  disp_vld;
  logic [31:0] disp_ins0, disp_addr0, disp_ins1, disp_addr1;
  logic        disp_spec0, disp_spec1;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spec_iq dut_i (.*);

  // bench model of the queue: index 0 is the oldest entry
  logic [31:0] m_ins [8];
  logic [31:0] m_addr [8];
  bit          m_spec [8];
  bit          m_br [8];
  int          mcnt = 0;
  bit          mact = 0;
  int unsigned seq = 0;

  // values expected in the current cycle
  bit       e_kill, e_clr, e_pacc, e_wspec;
  bit [1:0] e_rdy, e_vld;

  function automatic bit blocked(int i);
    return m_spec[i] && m_br[i];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_fetch(input bit [1:0] v, input bit b0, input bit b1);
    fetch_vld   = v;
    fetch_ins0  = 32'h1000_0000 + seq;
    fetch_addr0 = seq * 4;
    fetch_ins1  = 32'h1000_0000 + seq + 1;
    fetch_addr1 = (seq + 1) * 4;
    fetch_br0   = b0;
    fetch_br1   = b1;
    seq += 2;
  endtask

  // called in the low phase after inputs are driven
  task automatic settle();
    bit ok0, ok1;
    int fr;
    #1;
    e_kill  = bp_resolve && mact && bp_mispredict;
    e_clr   = bp_resolve && mact && !bp_mispredict;
    e_pacc  = bp_predict && (!mact || bp_resolve);
    e_wspec = (mact && !bp_resolve) || e_pacc;
    fr = 6 - mcnt;
    e_rdy = {!e_kill && fr >= 2, !e_kill && fr >= 1};
    ok0 = mcnt >= 1 && !blocked(0);
    ok1 = ok0 && mcnt >= 2 && !blocked(1);
    e_vld = (disp_stall || e_kill) ? 2'b00 : {ok1, ok0};
    chk(free_slots == 3'(fr), "R2 free_slots", free_slots, fr);
    chk(fetch_rdy == e_rdy, "R2 fetch_rdy", fetch_rdy, e_rdy);
    chk(disp_vld == e_vld, "R4 disp_vld", disp_vld, e_vld);
    if (e_vld[0]) begin
      chk(disp_ins0 == m_ins[0] && disp_addr0 == m_addr[0], "R3 slot0 order", disp_ins0, m_ins[0]);
      chk(disp_spec0 == m_spec[0], "R7 slot0 tag", disp_spec0, m_spec[0]);
    end
    if (e_vld[1]) begin
      chk(disp_ins1 == m_ins[1] && disp_addr1 == m_addr[1], "R3 slot1 order", disp_ins1, m_ins[1]);
      chk(disp_spec1 == m_spec[1], "R7 slot1 tag", disp_spec1, m_spec[1]);
    end
  endtask

  task automatic advance();
    int np;
    @(posedge clk);
    if (e_kill) begin
      while (mcnt > 0 && m_spec[mcnt-1]) mcnt--;
    end else begin
      if (e_clr) for (int i = 0; i < 8; i++) m_spec[i] = 0;
      np = disp_rdy ? (int'(e_vld[0]) + int'(e_vld[1])) : 0;
      for (int i = 0; i + np < 8; i++) begin
        m_ins[i] = m_ins[i+np]; m_addr[i] = m_addr[i+np];
        m_spec[i] = m_spec[i+np]; m_br[i] = m_br[i+np];
      end
      mcnt -= np;
      if (fetch_vld[0] && e_rdy[0]) begin
        m_ins[mcnt] = fetch_ins0; m_addr[mcnt] = fetch_addr0;
        m_spec[mcnt] = e_wspec; m_br[mcnt] = fetch_br0; mcnt++;
        if (fetch_vld[1] && e_rdy[1]) begin
          m_ins[mcnt] = fetch_ins1; m_addr[mcnt] = fetch_addr1;
          m_spec[mcnt] = e_wspec; m_br[mcnt] = fetch_br1; mcnt++;
        end
      end
    end
    if (e_pacc) mact = 1;
    else if (bp_resolve) mact = 0;
    @(negedge clk);
  endtask

  task automatic idle();
    fetch_vld = 2'b00; bp_predict = 0; bp_resolve = 0; bp_mispredict = 0;
    disp_stall = 0; disp_rdy = 0;
  endtask

  task automatic drain();
    idle();
    disp_rdy = 1;
    for (int i = 0; i < 20 && mcnt > 0; i++) begin settle(); advance(); end
    disp_rdy = 0;
  endtask

  initial begin
    logic [31:0] first_ins, n1_ins, s1_ins, s2_ins;
    logic [2:0]  fr_before;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(free_slots == 3'd6, "R1 reset free", free_slots, 6);
    chk(fetch_rdy == 2'b11, "R1 reset ready", fetch_rdy, 2'b11);
    chk(disp_vld == 2'b00, "R1 reset dispatch", disp_vld, 0);
    @(negedge clk);

    // fill to capacity, then offer more
    idle();
    first_ins = 32'h1000_0000 + seq;
    for (int k = 0; k < 3; k++) begin set_fetch(2'b11, 0, 0); settle(); advance(); end
    set_fetch(2'b11, 0, 0);
    settle();
    chk(free_slots == 3'd0, "R2 full", free_slots, 0);
    chk(fetch_rdy == 2'b00, "R2 full ready", fetch_rdy, 0);
    advance();
    fetch_vld = 2'b00;
    settle();
    chk(free_slots == 3'd0, "R6 no pop while not ready", free_slots, 0);
    advance();
    disp_stall = 1; disp_rdy = 1;
    settle();
    chk(disp_vld == 2'b00, "R5 stall blocks dispatch", disp_vld, 0);
    fr_before = free_slots;
    advance();
    disp_stall = 0;
    settle();
    chk(free_slots == fr_before, "R5 stall keeps occupancy", free_slots, fr_before);
    chk(disp_vld == 2'b11 && disp_ins0 == first_ins, "R3 oldest first", disp_ins0, first_ins);
    advance();
    drain();

    // speculative branch shadow and correct resolution
    set_fetch(2'b11, 0, 1); settle(); advance();
    bp_predict = 1;
    s1_ins = 32'h1000_0000 + seq; s2_ins = s1_ins + 1;
    set_fetch(2'b11, 0, 1); settle(); advance();
    bp_predict = 0;
    set_fetch(2'b01, 0, 0); settle(); advance();
    fetch_vld = 2'b00; disp_rdy = 1;
    settle();
    chk(disp_vld == 2'b11 && disp_spec0 == 0, "R4 pair before shadow", disp_vld, 2'b11);
    advance();
    settle();
    chk(disp_vld == 2'b01 && disp_ins0 == s1_ins, "R10 branch second blocks slot1", disp_vld, 2'b01);
    chk(disp_spec0 == 1'b1, "R7 tagged after predict", disp_spec0, 1);
    advance();
    settle();
    chk(disp_vld == 2'b00, "R10 branch at head held", disp_vld, 0);
    advance();
    bp_resolve = 1; bp_mispredict = 0;
    settle(); advance();
    bp_resolve = 0;
    settle();
    chk(disp_vld == 2'b11 && disp_ins0 == s2_ins, "R8 released after resolve", disp_ins0, s2_ins);
    chk(disp_spec0 == 1'b0, "R8 tag cleared", disp_spec0, 0);
    advance();
    drain();

    // misprediction flush with pending fetch
    n1_ins = 32'h1000_0000 + seq;
    set_fetch(2'b01, 0, 0); settle(); advance();
    bp_predict = 1;
    set_fetch(2'b11, 0, 0); settle(); advance();
    bp_predict = 0;
    bp_resolve = 1; bp_mispredict = 1; disp_rdy = 1;
    set_fetch(2'b11, 0, 0);
    settle();
    chk(fetch_rdy == 2'b00, "R9 fetch refused in flush", fetch_rdy, 0);
    chk(disp_vld == 2'b00, "R9 no dispatch in flush", disp_vld, 0);
    advance();
    bp_resolve = 0; bp_mispredict = 0; fetch_vld = 2'b00;
    settle();
    chk(free_slots == 3'd5, "R9 only older entry kept", free_slots, 5);
    chk(disp_vld == 2'b01 && disp_ins0 == n1_ins && disp_spec0 == 0, "R9 survivor at head", disp_ins0, n1_ins);
    advance();
    drain();

    // constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      set_fetch(2'($urandom % 4), ($urandom % 4) == 0, ($urandom % 4) == 0);
      bp_predict    = ($urandom % 10) == 0;
      bp_resolve    = ($urandom % 12) == 0;
      bp_mispredict = ($urandom % 2) == 0;
      disp_stall    = ($urandom % 8) == 0;
      disp_rdy      = ($urandom % 4) != 0;
      settle();
      advance();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule